// File: doc/BRIEF.md
# Shared-Slave Arbiter with Locked Sequences

This block sits in front of one shared slave port and decides which of several bus masters may present a request in a given cycle. Each master raises a request valid. The request carries a lock flag and a read/write indication. When no lock is active, the arbiter serves the requesting masters in rotating order and accepts at most one transaction per cycle. The slave reports each finished transaction over a shared completion handshake that names the master it belonged to. A small counter per master tracks that master's transactions in flight.

A request accepted with its lock flag set reserves the slave for the master that sent it. From then on that master keeps ownership across any number of locked transactions. The sequence is closed by the owner's first request without the lock flag. That closing transaction is still served exclusively. Once it is accepted, nobody is granted, not even the owner. The lock is dropped only when the owner's outstanding transactions have all completed.

Masters that are blocked are stalled by holding their ready low. They never receive an error. A locked request cannot open a sequence while its master still has transactions in flight. It waits, and other masters may be served meanwhile.

Top module: `lkarb_top`

## Requirements
- R1: While reset is held and after reset with no request valid, `s_valid`, `m_grant` and `m_ready` are all zero, no lock is active and every outstanding counter is zero. The first master considered after reset is index 0.
- R2: In any cycle at most one bit of `m_grant` is set. `s_valid` is 1 exactly when one is set. `s_src` gives the granted index, and `s_write`/`s_lock` copy that master's `m_write`/`m_lock`. Grant is combinational from the current requests and the registered state.
- R3: `m_ready[m]` is 1 only when master m is granted and `s_ready` is 1. A transaction is accepted on a clock edge where `s_valid` and `s_ready` are both 1. A grant with `s_ready` low accepts nothing and leaves the rotation unchanged.
- R4: With no lock active, the grant goes to the first eligible requesting master found by searching upward from the index after the last accepted master, wrapping from NUM_M-1 to 0.
- R5: From the cycle after a locked request is accepted with no lock active, only the issuing master can be granted. Every other master sees `m_ready` low even with `s_ready` high.
- R6: The owner keeps the slave across any number of accepted locked transactions. Cycles in which the owner does not request grant nobody.
- R7: After the owner's first unlocked request is accepted, no master is granted. The lock clears on the edge at which a completion for the owner brings its outstanding count to zero. From the next cycle, rotating arbitration resumes.
- R8: With no lock active, a locked request from a master whose outstanding count is nonzero is not granted. Other eligible masters may be granted in its place. The request becomes grantable once that master's count is zero.
- R9: A master's count rises by one on each accepted transaction and falls by one on each completion with `c_valid`=1 and `c_src` equal to its index. A master whose count is at its maximum (2^PEND_W - 1) is not granted.
- R10: Asserting `rst_n` low in the middle of a locked sequence clears the lock, the owner, all outstanding counters and the rotation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| m_valid | input | NUM_M | Request valid per master |
| m_lock | input | NUM_M | Lock flag per master's request |
| m_write | input | NUM_M | Write (1) or read (0) per master's request |
| m_ready | output | NUM_M | Request accepted this cycle, per master |
| m_grant | output | NUM_M | One-hot grant of the slave port this cycle |
| s_valid | output | 1 | A granted request is presented to the slave |
| s_src | output | clog2(NUM_M) | Index of the granted master |
| s_write | output | 1 | Write flag of the granted request |
| s_lock | output | 1 | Lock flag of the granted request |
| s_ready | input | 1 | Slave accepts the presented request |
| c_valid | input | 1 | A transaction completed at the slave |
| c_src | input | clog2(NUM_M) | Master owning the completed transaction |

## Verification
Grant, ready and the slave-side copies of a request are combinational, so they are due in the same cycle the request inputs are applied. Lock ownership, the drain state, the rotation pointer and the outstanding counters change on the edge of an acceptance or completion, and their effect is due one cycle later. The bench changes inputs just after the falling edge and samples one nanosecond later, well before the next rising edge. Each state effect is therefore checked in the cycle after the edge that caused it. Stalls are checked by holding `s_ready` low or by looking for an all-zero grant, so no state moves while the check is made.

// File: rtl/lkarb_pkg.sv
package lkarb_pkg;

  // Ownership state of the shared slave
  typedef enum logic [1:0] {
    LK_IDLE  = 2'd0,  // rotating arbitration
    LK_HELD  = 2'd1,  // one master owns the slave
    LK_DRAIN = 2'd2   // closing request accepted, waiting for owner to empty
  } lk_state_e;

endpackage

// File: rtl/lkarb_rr_pick.sv
module lkarb_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  elig,
  input  logic          adv,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);

  logic [IW-1:0] ptr_q;

  always_comb begin
    int            sum_i;
    logic [IW-1:0] cand;
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int k = 1; k <= N; k++) begin
      sum_i = int'(ptr_q) + k;
      if (sum_i >= N) sum_i = sum_i - N;
      cand = IW'(sum_i);
      if (!any && elig[cand]) begin
        any     = 1'b1;
        gnt_idx = cand;
      end
    end
    if (any) gnt[gnt_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= IW'(N - 1);
    end else if (adv) begin
      ptr_q <= gnt_idx;
    end
  end

  // R2
  one_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R4
  pick_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~elig) == '0);

endmodule

// File: rtl/lkarb_pend_cnt.sv
module lkarb_pend_cnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         nz,
  output logic         full,
  output logic         one
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         dec_ok, cnt_en;

  assign dec_ok = dec && (cnt_q != '0);
  assign cnt_en = inc ^ dec_ok;

  always_comb begin
    cnt_d = cnt_q;
    if (inc) cnt_d = cnt_q + 1'b1;
    else if (dec_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt  = cnt_q;
  assign nz   = (cnt_q != '0);
  assign full = (cnt_q == '1);
  assign one  = (cnt_q == W'(1));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !inc);

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/lkarb_lock_ctl.sv
module lkarb_lock_ctl
  import lkarb_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [IW-1:0] acc_src,
  input  logic          acc_lock,
  input  logic          c_valid,
  input  logic [IW-1:0] c_src,
  input  logic [N-1:0]  pend_one,
  input  logic [N-1:0]  gnt,
  output lk_state_e     st,
  output logic [IW-1:0] owner
);

  lk_state_e     st_q, st_d;
  logic [IW-1:0] owner_q, owner_d;
  logic          st_en;
  logic          own_done;
  logic [N-1:0]  own_mask;

  assign own_done = c_valid && (c_src == owner_q) && pend_one[owner_q];

  always_comb begin
    st_d    = st_q;
    owner_d = owner_q;
    unique case (st_q)
      LK_IDLE: begin
        if (acc && acc_lock) begin
          st_d    = LK_HELD;
          owner_d = acc_src;
        end
      end
      LK_HELD: begin
        if (acc && !acc_lock) st_d = LK_DRAIN;
      end
      LK_DRAIN: begin
        if (own_done) st_d = LK_IDLE;
      end
      default: st_d = LK_IDLE;
    endcase
  end

  assign st_en = (st_d != st_q) || (owner_d != owner_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= LK_IDLE;
      owner_q <= '0;
    end else if (st_en) begin
      st_q    <= st_d;
      owner_q <= owner_d;
    end
  end

  assign st    = st_q;
  assign owner = owner_q;

  always_comb begin
    own_mask          = '0;
    own_mask[owner_q] = 1'b1;
  end

  // R5
  held_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LK_HELD) |-> ((gnt & ~own_mask) == '0));

  // R6
  held_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LK_HELD && acc && acc_lock) |=> (st_q == LK_HELD));

  // R7
  drain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LK_DRAIN) |-> (gnt == '0));

  // R7
  release_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LK_IDLE && $past(st_q) == LK_DRAIN) |-> $past(c_valid && c_src == owner_q));

endmodule

// File: rtl/lkarb_top.sv
module lkarb_top
  import lkarb_pkg::*;
#(
  parameter int NUM_M  = 4,
  parameter int PEND_W = 3,
  localparam int IW    = $clog2(NUM_M)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_M-1:0] m_valid,
  input  logic [NUM_M-1:0] m_lock,
  input  logic [NUM_M-1:0] m_write,
  output logic [NUM_M-1:0] m_ready,
  output logic [NUM_M-1:0] m_grant,
  output logic             s_valid,
  output logic [IW-1:0]    s_src,
  output logic             s_write,
  output logic             s_lock,
  input  logic             s_ready,
  input  logic             c_valid,
  input  logic [IW-1:0]    c_src
);

  lk_state_e        st;
  logic [IW-1:0]    owner;
  logic [NUM_M-1:0] elig;
  logic [NUM_M-1:0] gnt;
  logic [IW-1:0]    gnt_idx;
  logic             any;
  logic             acc;
  logic [NUM_M-1:0] pend_nz, pend_full, pend_one;
  logic [PEND_W-1:0] pend_cnt [NUM_M];

  // Eligibility per master under the current ownership state
  always_comb begin
    for (int m = 0; m < NUM_M; m++) begin
      unique case (st)
        LK_IDLE:  elig[m] = m_valid[m] && !pend_full[m] && !(m_lock[m] && pend_nz[m]);
        LK_HELD:  elig[m] = m_valid[m] && !pend_full[m] && (owner == IW'(m));
        default:  elig[m] = 1'b0;
      endcase
    end
  end

  lkarb_rr_pick #(.N(NUM_M), .IW(IW)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .elig    (elig),
    .adv     (acc),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .any     (any)
  );

  assign acc     = any && s_ready;
  assign m_grant = gnt;
  assign m_ready = gnt & {NUM_M{s_ready}};
  assign s_valid = any;
  assign s_src   = gnt_idx;
  assign s_write = any && m_write[gnt_idx];
  assign s_lock  = any && m_lock[gnt_idx];

  for (genvar g = 0; g < NUM_M; g++) begin : g_pend
    lkarb_pend_cnt #(.W(PEND_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (acc && gnt[g]),
      .dec   (c_valid && (c_src == IW'(g))),
      .cnt   (pend_cnt[g]),
      .nz    (pend_nz[g]),
      .full  (pend_full[g]),
      .one   (pend_one[g])
    );
  end

  lkarb_lock_ctl #(.N(NUM_M), .IW(IW)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .acc_src  (gnt_idx),
    .acc_lock (s_lock),
    .c_valid  (c_valid),
    .c_src    (c_src),
    .pend_one (pend_one),
    .gnt      (gnt),
    .st       (st),
    .owner    (owner)
  );

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_grant));

  // R8
  lock_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_lock && st == LK_IDLE) |-> (pend_cnt[s_src] == '0));

  // R3
  ready_slave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready |-> (m_ready == '0));

endmodule

// File: tb/tb_lkarb_top.sv
`timescale 1ns/1ps
module tb_lkarb_top;

  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] m_valid, m_lock, m_write;
  logic [N-1:0] m_ready, m_grant;
  logic         s_valid, s_write, s_lock, s_ready, c_valid;
  logic [1:0]   s_src, c_src;

  int vec = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lkarb_top #(.NUM_M(N), .PEND_W(2)) dut (
    .clk(clk), .rst_n(rst_n),
    .m_valid(m_valid), .m_lock(m_lock), .m_write(m_write),
    .m_ready(m_ready), .m_grant(m_grant),
    .s_valid(s_valid), .s_src(s_src), .s_write(s_write), .s_lock(s_lock),
    .s_ready(s_ready), .c_valid(c_valid), .c_src(c_src)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic drive(logic [N-1:0] v, logic [N-1:0] l, logic sr, logic cv, int cs);
    m_valid = v;
    m_lock  = l;
    s_ready = sr;
    c_valid = cv;
    c_src   = 2'(cs);
    #1;
  endtask

  function automatic int rr_win(int last, int pat);
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (last + k) % N;
      if (pat[idx]) return idx;
    end
    return -1;
  endfunction

  function automatic logic [31:0] oh(int i);
    return (i < 0) ? 32'd0 : (32'd1 << i);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int last;
    rst_n = 1'b0; m_write = '0;
    drive('0, '0, 1'b1, 1'b0, 0);
    repeat (3) nxt();
    rst_n = 1'b1;
    drive('0, '0, 1'b1, 1'b0, 0);
    // R1: quiet after reset
    chk("R1 s_valid", s_valid, 0);
    chk("R1 m_grant", m_grant, 0);
    chk("R1 m_ready", m_ready, 0);
    nxt();

    // R2 R3 R4: sweep all request patterns, rotation tracked here
    last = N - 1;
    for (int rep = 0; rep < 3; rep++) begin
      for (int pat = 1; pat < (1 << N); pat++) begin
        int w;
        w = rr_win(last, pat);
        m_write = 3'(pat ^ 5);
        drive(3'(pat), '0, 1'b0, 1'b0, 0);
        chk("R4 grant", m_grant, oh(w));
        chk("R3 ready low", m_ready, 0);
        chk("R2 s_src", s_src, w);
        chk("R2 s_write", s_write, ((pat ^ 5) >> w) & 1);
        chk("R2 s_lock", s_lock, 0);
        nxt();
        drive(3'(pat), '0, 1'b1, 1'b0, 0);
        chk("R3 ready", m_ready, oh(w));
        chk("R2 s_valid", s_valid, 1);
        nxt();
        last = w;
        drive('0, '0, 1'b1, 1'b1, w);
        chk("R2 idle", s_valid, 0);
        nxt();
      end
    end

    // R5 R6 R7: master 1 locked sequence
    m_write = '0;
    drive(3'b010, 3'b010, 1'b1, 1'b0, 0);
    chk("R5 open", m_grant, 3'b010);
    nxt();                                   // held, p1=1
    drive(3'b111, 3'b010, 1'b1, 1'b0, 0);
    chk("R5 owner only", m_grant, 3'b010);
    chk("R5 others stall", m_ready & 3'b101, 0);
    nxt();                                   // p1=2
    drive(3'b101, 3'b000, 1'b1, 1'b1, 1);
    chk("R6 owner idle", m_grant, 0);
    nxt();                                   // p1=1
    drive(3'b111, 3'b010, 1'b1, 1'b0, 0);
    chk("R6 still held", m_grant, 3'b010);
    nxt();                                   // p1=2
    drive(3'b111, 3'b000, 1'b1, 1'b0, 0);
    chk("R7 closing grant", m_grant, 3'b010);
    chk("R7 closing unlocked", s_lock, 0);
    nxt();                                   // drain, p1=3
    drive(3'b111, 3'b000, 1'b1, 1'b1, 1);
    chk("R7 drain blocks", m_grant, 0);
    nxt();                                   // p1=2
    drive(3'b111, 3'b000, 1'b1, 1'b1, 1);
    chk("R7 drain blocks", m_grant, 0);
    nxt();                                   // p1=1
    drive(3'b111, 3'b000, 1'b1, 1'b1, 1);
    chk("R7 last completion", m_grant, 0);
    nxt();                                   // p1=0, released
    drive(3'b111, 3'b000, 1'b0, 1'b0, 0);
    chk("R7 released", m_grant, 3'b100);
    nxt();

    // R8: locked request with work in flight waits
    drive(3'b001, 3'b000, 1'b1, 1'b0, 0);
    chk("R8 setup", m_grant, 3'b001);
    nxt();                                   // p0=1
    drive(3'b101, 3'b001, 1'b1, 1'b0, 0);
    chk("R8 other served", m_grant, 3'b100);
    nxt();                                   // p2=1
    drive(3'b001, 3'b001, 1'b1, 1'b1, 2);
    chk("R8 lock waits", m_grant, 0);
    nxt();                                   // p2=0
    drive(3'b001, 3'b001, 1'b1, 1'b1, 0);
    chk("R8 lock waits", m_grant, 0);
    nxt();                                   // p0=0
    drive(3'b001, 3'b001, 1'b1, 1'b0, 0);
    chk("R8 lock granted", m_grant, 3'b001);
    nxt();                                   // held, p0=1
    drive(3'b001, 3'b000, 1'b1, 1'b0, 0);
    chk("R8 close", m_grant, 3'b001);
    nxt();                                   // drain, p0=2
    drive('0, '0, 1'b1, 1'b1, 0);
    nxt();
    drive('0, '0, 1'b1, 1'b1, 0);
    nxt();                                   // released
    drive(3'b100, 3'b000, 1'b0, 1'b0, 0);
    chk("R7 after drain", m_grant, 3'b100);
    nxt();

    // R9: counter limit of 3
    for (int i = 0; i < 3; i++) begin
      drive(3'b100, 3'b000, 1'b1, 1'b0, 0);
      chk("R9 fill", m_grant, 3'b100);
      nxt();
    end
    drive(3'b100, 3'b000, 1'b1, 1'b1, 2);
    chk("R9 full blocks", m_grant, 0);
    nxt();                                   // p2=2
    drive(3'b100, 3'b000, 1'b0, 1'b0, 0);
    chk("R9 room again", m_grant, 3'b100);
    nxt();
    drive('0, '0, 1'b1, 1'b1, 2);
    nxt();
    drive('0, '0, 1'b1, 1'b1, 2);
    nxt();

    // R10: reset in the middle of a lock
    drive(3'b010, 3'b010, 1'b1, 1'b0, 0);
    chk("R10 open", m_grant, 3'b010);
    nxt();                                   // held by 1, p1=1
    drive(3'b001, 3'b000, 1'b1, 1'b0, 0);
    chk("R10 held", m_grant, 0);
    rst_n = 1'b0;
    nxt();
    rst_n = 1'b1;
    drive(3'b011, 3'b000, 1'b0, 1'b0, 0);
    chk("R10 lock cleared", m_grant, 3'b001);
    drive(3'b010, 3'b010, 1'b0, 1'b0, 0);
    chk("R10 count cleared", m_grant, 3'b010);
    drive('0, '0, 1'b1, 1'b0, 0);
    chk("R1 quiet again", s_valid, 0);
    nxt();

    finish_run();
  end

endmodule